// File: doc/BRIEF.md
# Legacy System Control and CMOS Gate

This block gathers three small system-control functions that sit on an 8-bit I/O bus. The first is a control register at port 92h. It fires a fixed-length CPU reset pulse when its reset bit goes from 0 to 1. It also supplies a fast A20 gate, which is ORed with an external A20 request.

The second function is the index/data path to the real-time-clock CMOS RAM. Port 70h selects a location and port 71h reads or writes it. A one-way lock, which can only be armed while a configuration enable is high, shuts off access to the protected range 38h..3Fh until the next system reset.

The third function is a coprocessor error latch. It drives IRQ13 and is cleared by any write to port F0h or F1h.

Bus reads are combinational. The RAM is external, with a combinational read port addressed by the index output and a write strobe that is sampled on the clock edge.

Top module: `legacy_sysctl`

## Requirements
- R1: After reset, port 92h reads 00h, `cpu_rst_o` and `irq13_o` are 0, the index is 0 and `a20_mask_o` is 1 while `ext_a20_i` is 0.
- R2: A write to 70h loads the low 7 bits of the data into the CMOS index. Reads and writes of 71h then access that location: `cmos_re_o` or `cmos_we_o` is asserted and data passes through.
- R3: A write to 92h with bit 0 = 1, when the stored bit 0 is 0, raises `cpu_rst_o` from the next clock edge for exactly RST_PULSE cycles.
- R4: Writing 1 to bit 0 of 92h while it already holds 1 does not start a new reset pulse.
- R5: `a20_mask_o` is 1 only when bit 1 of 92h and `ext_a20_i` are both 0.
- R6: While `lock_en_i` is 0, writing 1 to bit 3 of 92h sets no lock, and bit 3 reads as 0.
- R7: While `lock_en_i` is 1, writing 1 to bit 3 sets the lock, which reads back as 1. Writing 0 to bit 3 never clears it.
- R8: While locked, a read of 71h with the index in 38h..3Fh returns FFh with no `cmos_re_o`, and a write there gives no `cmos_we_o`. Locations outside that range are unaffected.
- R9: Only `rst_ni` clears the lock.
- R10: A rising edge on `fpu_err_i` sets `irq13_o` on the next edge, and it holds until any write to F0h or F1h clears it, whatever the data.
- R11: Bits 2 and 7:4 of port 92h always read 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_wr_i | input | 1 | I/O write strobe, one cycle per access |
| io_rd_i | input | 1 | I/O read strobe |
| io_rdata_o | output | 8 | I/O read data (combinational) |
| lock_en_i | input | 1 | Configuration enable for the CMOS lock |
| ext_a20_i | input | 1 | External A20 gate request |
| fpu_err_i | input | 1 | Coprocessor error input |
| cmos_addr_o | output | 7 | CMOS RAM location (current index) |
| cmos_wdata_o | output | 8 | CMOS RAM write data |
| cmos_we_o | output | 1 | CMOS RAM write strobe |
| cmos_re_o | output | 1 | CMOS RAM read strobe |
| cmos_rdata_i | input | 8 | CMOS RAM read data |
| cpu_rst_o | output | 1 | CPU reset pulse |
| a20_mask_o | output | 1 | A20 mask, high means masked |
| irq13_o | output | 1 | Coprocessor error interrupt |

## Verification
The bench first walks a table of CMOS locations on both sides of the 38h..3Fh boundary, once unlocked and once locked. A gate with an off-by-one range would leak 37h or 40h, or would miss 38h or 3Fh. It then rewrites the reset bit while it already holds 1 and measures each pulse. A level-triggered reset would fire again, and a miscounted counter would give the wrong width. It also tries to arm the lock with the enable low and to clear it in software; a lock that is not sticky or not gated would show up in the readback and in the blocked reads. Finally, it holds the coprocessor error high across a clear, and it clears with arbitrary data from both ports. A level-set latch would reassert at once, and a data-dependent clear would leave IRQ13 high.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned PORT_CTRL  = 'h92;
  localparam int unsigned PORT_INDEX = 'h70;
  localparam int unsigned PORT_DATA  = 'h71;
  localparam int unsigned PORT_ERR0  = 'hF0;
  localparam int unsigned PORT_ERR1  = 'hF1;

  // bit positions of the control register
  localparam int unsigned B_RST  = 0;
  localparam int unsigned B_A20  = 1;
  localparam int unsigned B_LOCK = 3;

  typedef struct packed {
    logic rst_bit;
    logic fast_a20;
    logic lock;
  } ctrl_state_t;
endpackage

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg #(
  parameter int unsigned RST_PULSE = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   lock_en_i,
  input  logic                   ext_a20_i,
  output sysctl_pkg::ctrl_state_t st_o,
  output logic [7:0]             rdata_o,
  output logic                   cpu_rst_o,
  output logic                   a20_mask_o
);
  import sysctl_pkg::*;

  localparam int unsigned CW = $clog2(RST_PULSE + 1);

  ctrl_state_t st_q;
  logic [CW-1:0] cnt_q;
  logic fire;

  assign fire = wr_i && wdata_i[B_RST] && !st_q.rst_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) begin
        st_q.rst_bit  <= wdata_i[B_RST];
        st_q.fast_a20 <= wdata_i[B_A20];
        // one-way: set only when enabled, never cleared by software
        if (lock_en_i && wdata_i[B_LOCK]) st_q.lock <= 1'b1;
      end
      if (fire)              cnt_q <= CW'(RST_PULSE);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign st_o       = st_q;
  assign cpu_rst_o  = (cnt_q != '0);
  assign a20_mask_o = !(st_q.fast_a20 || ext_a20_i);

  always_comb begin
    rdata_o         = '0;
    rdata_o[B_RST]  = st_q.rst_bit;
    rdata_o[B_A20]  = st_q.fast_a20;
    rdata_o[B_LOCK] = st_q.lock && lock_en_i;
  end
endmodule

// File: rtl/sysctl_cmos_path.sv
module sysctl_cmos_path #(
  parameter int unsigned       CMOS_AW = 7,
  parameter logic [CMOS_AW-1:0] LOCK_LO = 7'h38,
  parameter logic [CMOS_AW-1:0] LOCK_HI = 7'h3F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idx_wr_i,
  input  logic               dat_wr_i,
  input  logic               dat_rd_i,
  input  logic [7:0]         wdata_i,
  input  logic               lock_i,
  input  logic [7:0]         cmos_rdata_i,
  output logic [CMOS_AW-1:0] cmos_addr_o,
  output logic [7:0]         cmos_wdata_o,
  output logic               cmos_we_o,
  output logic               cmos_re_o,
  output logic [7:0]         idx_rdata_o,
  output logic [7:0]         dat_rdata_o
);
  logic [CMOS_AW-1:0] idx_q;
  logic in_range, blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_wr_i) idx_q <= wdata_i[CMOS_AW-1:0];
  end

  assign in_range = (idx_q >= LOCK_LO) && (idx_q <= LOCK_HI);
  assign blocked  = lock_i && in_range;

  assign cmos_addr_o  = idx_q;
  assign cmos_wdata_o = wdata_i;
  assign cmos_we_o    = dat_wr_i && !blocked;
  assign cmos_re_o    = dat_rd_i && !blocked;
  assign idx_rdata_o  = 8'(idx_q);
  assign dat_rdata_o  = blocked ? 8'hFF : cmos_rdata_i;
endmodule

// File: rtl/sysctl_err_latch.sv
module sysctl_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic clr_i,
  output logic irq_o
);
  logic err_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      err_q <= err_i;
      // a fresh edge wins over a simultaneous clear
      if (err_i && !err_q) irq_q <= 1'b1;
      else if (clr_i)      irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/legacy_sysctl.sv
module legacy_sysctl #(
  parameter int unsigned IO_AW     = 16,
  parameter int unsigned CMOS_AW   = 7,
  parameter int unsigned RST_PULSE = 4,
  parameter logic [CMOS_AW-1:0] LOCK_LO = 7'h38,
  parameter logic [CMOS_AW-1:0] LOCK_HI = 7'h3F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic [7:0]         io_wdata_i,
  input  logic               io_wr_i,
  input  logic               io_rd_i,
  output logic [7:0]         io_rdata_o,
  input  logic               lock_en_i,
  input  logic               ext_a20_i,
  input  logic               fpu_err_i,
  output logic [CMOS_AW-1:0] cmos_addr_o,
  output logic [7:0]         cmos_wdata_o,
  output logic               cmos_we_o,
  output logic               cmos_re_o,
  input  logic [7:0]         cmos_rdata_i,
  output logic               cpu_rst_o,
  output logic               a20_mask_o,
  output logic               irq13_o
);
  import sysctl_pkg::*;

  logic hit_ctrl, hit_idx, hit_dat, hit_err;
  ctrl_state_t ctrl_st;
  logic [7:0] ctrl_rdata, idx_rdata, dat_rdata;

  assign hit_ctrl = (io_addr_i == IO_AW'(PORT_CTRL));
  assign hit_idx  = (io_addr_i == IO_AW'(PORT_INDEX));
  assign hit_dat  = (io_addr_i == IO_AW'(PORT_DATA));
  assign hit_err  = (io_addr_i == IO_AW'(PORT_ERR0)) || (io_addr_i == IO_AW'(PORT_ERR1));

  sysctl_ctrl_reg #(.RST_PULSE(RST_PULSE)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (io_wr_i && hit_ctrl),
    .wdata_i    (io_wdata_i),
    .lock_en_i  (lock_en_i),
    .ext_a20_i  (ext_a20_i),
    .st_o       (ctrl_st),
    .rdata_o    (ctrl_rdata),
    .cpu_rst_o  (cpu_rst_o),
    .a20_mask_o (a20_mask_o)
  );

  sysctl_cmos_path #(.CMOS_AW(CMOS_AW), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI)) u_cmos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_wr_i     (io_wr_i && hit_idx),
    .dat_wr_i     (io_wr_i && hit_dat),
    .dat_rd_i     (io_rd_i && hit_dat),
    .wdata_i      (io_wdata_i),
    .lock_i       (ctrl_st.lock),
    .cmos_rdata_i (cmos_rdata_i),
    .cmos_addr_o  (cmos_addr_o),
    .cmos_wdata_o (cmos_wdata_o),
    .cmos_we_o    (cmos_we_o),
    .cmos_re_o    (cmos_re_o),
    .idx_rdata_o  (idx_rdata),
    .dat_rdata_o  (dat_rdata)
  );

  sysctl_err_latch u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_i  (fpu_err_i),
    .clr_i  (io_wr_i && hit_err),
    .irq_o  (irq13_o)
  );

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      if (hit_ctrl)     io_rdata_o = ctrl_rdata;
      else if (hit_idx) io_rdata_o = idx_rdata;
      else if (hit_dat) io_rdata_o = dat_rdata;
    end
  end
endmodule

// File: rtl/legacy_sysctl_chk.sv
module legacy_sysctl_chk #(
  parameter int unsigned IO_AW   = 16,
  parameter int unsigned CMOS_AW = 7,
  parameter logic [CMOS_AW-1:0] LOCK_LO = 7'h38,
  parameter logic [CMOS_AW-1:0] LOCK_HI = 7'h3F
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [IO_AW-1:0]   io_addr_i,
  input logic [7:0]         io_wdata_i,
  input logic               io_wr_i,
  input logic               io_rd_i,
  input logic [7:0]         io_rdata_o,
  input logic               lock_en_i,
  input logic               ext_a20_i,
  input logic               fpu_err_i,
  input logic [CMOS_AW-1:0] cmos_addr_o,
  input logic               cmos_we_o,
  input logic               cmos_re_o,
  input logic               cpu_rst_o,
  input logic               a20_mask_o,
  input logic               irq13_o,
  input logic               lock_q
);
  import sysctl_pkg::*;

  logic prot;
  assign prot = lock_q && (cmos_addr_o >= LOCK_LO) && (cmos_addr_o <= LOCK_HI);

  assert_idx_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(io_wr_i && io_addr_i == IO_AW'(PORT_INDEX)) |-> $stable(cmos_addr_o));

  assert_rst_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> $past(io_wr_i && io_addr_i == IO_AW'(PORT_CTRL) && io_wdata_i[B_RST]));

  assert_a20_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_a20_i |-> !a20_mask_o);

  assert_lock_readzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_en_i && io_rd_i && io_addr_i == IO_AW'(PORT_CTRL)) |-> !io_rdata_o[B_LOCK]);

  assert_blocked_no_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot |-> (!cmos_we_o && !cmos_re_o));

  assert_lock_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_q) |-> lock_q);

  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq13_o) |-> $past(fpu_err_i));

  assert_reserved_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == IO_AW'(PORT_CTRL)) |-> (io_rdata_o[7:4] == 4'h0 && !io_rdata_o[2]));
endmodule

bind legacy_sysctl legacy_sysctl_chk #(
  .IO_AW(IO_AW), .CMOS_AW(CMOS_AW), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_addr_i   (io_addr_i),
  .io_wdata_i  (io_wdata_i),
  .io_wr_i     (io_wr_i),
  .io_rd_i     (io_rd_i),
  .io_rdata_o  (io_rdata_o),
  .lock_en_i   (lock_en_i),
  .ext_a20_i   (ext_a20_i),
  .fpu_err_i   (fpu_err_i),
  .cmos_addr_o (cmos_addr_o),
  .cmos_we_o   (cmos_we_o),
  .cmos_re_o   (cmos_re_o),
  .cpu_rst_o   (cpu_rst_o),
  .a20_mask_o  (a20_mask_o),
  .irq13_o     (irq13_o),
  .lock_q      (ctrl_st.lock)
);

// File: tb/legacy_sysctl_tb.sv
module legacy_sysctl_tb;
  localparam int unsigned RST_PULSE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic wr = 1'b0, rd = 1'b0;
  logic lock_en = 1'b0, ext_a20 = 1'b0, fpu_err = 1'b0;
  logic [6:0] c_addr;
  logic [7:0] c_wdata, c_rdata;
  logic c_we, c_re, cpu_rst, a20_mask, irq13;

  int checks = 0, errors = 0;
  logic last_we;
  logic [7:0] ram [128];

  always #2.5 clk = ~clk;

  legacy_sysctl #(.RST_PULSE(RST_PULSE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_wr_i(wr), .io_rd_i(rd), .io_rdata_o(rdata), .lock_en_i(lock_en),
    .ext_a20_i(ext_a20), .fpu_err_i(fpu_err), .cmos_addr_o(c_addr),
    .cmos_wdata_o(c_wdata), .cmos_we_o(c_we), .cmos_re_o(c_re),
    .cmos_rdata_i(c_rdata), .cpu_rst_o(cpu_rst), .a20_mask_o(a20_mask),
    .irq13_o(irq13)
  );

  // external RAM model
  assign c_rdata = ram[c_addr];
  always @(posedge clk) if (c_we) ram[c_addr] <= c_wdata;

  // {index, data}
  localparam logic [15:0] VEC [8] = '{
    16'h0511, 16'h3722, 16'h3833, 16'h3A44,
    16'h3F55, 16'h4066, 16'h7F77, 16'h0E88
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #1 last_we = c_we;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic re);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata; re = c_re;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic prot(input logic [7:0] i);
    return i >= 8'h38 && i <= 8'h3F;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic re;
    int n;
    for (int i = 0; i < 128; i++) ram[i] = 8'h00;
    do_reset();

    // R1 reset state
    io_read(16'h92, d, re);
    chk("R1 ctrl", d, 8'h00);
    chk("R1 cpu_rst", cpu_rst, 0);
    chk("R1 irq13", irq13, 0);
    chk("R1 a20_mask", a20_mask, 1);
    chk("R1 index", c_addr, 0);

    // R11 reserved bits
    io_write(16'h92, 8'hF4);
    io_read(16'h92, d, re);
    chk("R11 reserved", d, 8'h00);

    // R2 table walk, unlocked
    foreach (VEC[k]) begin
      io_write(16'h70, VEC[k][15:8]);
      io_write(16'h71, VEC[k][7:0]);
      chk("R2 write strobe", last_we, 1);
    end
    foreach (VEC[k]) begin
      io_write(16'h70, VEC[k][15:8]);
      io_read(16'h71, d, re);
      chk("R2 readback", d, VEC[k][7:0]);
      chk("R2 read strobe", re, 1);
    end

    // R3 pulse
    io_write(16'h92, 8'h01);
    chk("R3 start", cpu_rst, 1);
    n = 0;
    while (cpu_rst && n < 100) begin n++; @(negedge clk); end
    chk("R3 width", n, RST_PULSE);
    // R4 no retrigger while held at 1
    io_write(16'h92, 8'h01);
    n = 0;
    repeat (RST_PULSE + 2) begin @(negedge clk); if (cpu_rst) n++; end
    chk("R4 no retrigger", n, 0);
    io_write(16'h92, 8'h00);
    io_write(16'h92, 8'h01);
    n = 0;
    while (cpu_rst && n < 100) begin n++; @(negedge clk); end
    chk("R3 second pulse", n, RST_PULSE);
    io_write(16'h92, 8'h00);

    // R5 A20
    chk("R5 none", a20_mask, 1);
    io_write(16'h92, 8'h02);
    chk("R5 fast", a20_mask, 0);
    ext_a20 = 1'b1;
    #1 chk("R5 both", a20_mask, 0);
    io_write(16'h92, 8'h00);
    chk("R5 ext", a20_mask, 0);
    ext_a20 = 1'b0;
    #1 chk("R5 released", a20_mask, 1);

    // R6 lock gated off
    io_write(16'h92, 8'h08);
    io_read(16'h92, d, re);
    chk("R6 reads zero", d, 8'h00);
    lock_en = 1'b1;
    io_read(16'h92, d, re);
    chk("R6 not armed", d, 8'h00);
    io_write(16'h70, 8'h38);
    io_read(16'h71, d, re);
    chk("R6 range open", d, 8'h33);

    // R7 arm and try to clear
    io_write(16'h92, 8'h08);
    io_read(16'h92, d, re);
    chk("R7 set", d, 8'h08);
    io_write(16'h92, 8'h00);
    io_read(16'h92, d, re);
    chk("R7 sticky", d, 8'h08);

    // R8 locked table walk
    foreach (VEC[k]) begin
      io_write(16'h70, VEC[k][15:8]);
      io_write(16'h71, 8'hC3);
      chk("R8 write strobe", last_we, !prot(VEC[k][15:8]));
      io_read(16'h71, d, re);
      chk("R8 read", d, prot(VEC[k][15:8]) ? 8'hFF : 8'hC3);
      chk("R8 read strobe", re, !prot(VEC[k][15:8]));
    end

    // R9 only reset clears
    do_reset();
    io_read(16'h92, d, re);
    chk("R9 cleared", d, 8'h00);
    io_write(16'h70, 8'h3A);
    io_read(16'h71, d, re);
    chk("R9 range reopened", d, 8'h44);

    // R10 error latch
    @(negedge clk) fpu_err = 1'b1;
    @(negedge clk) chk("R10 set", irq13, 1);
    io_write(16'hF0, 8'h5A);
    chk("R10 clear F0", irq13, 0);
    repeat (3) @(negedge clk);
    chk("R10 held level no reset", irq13, 0);
    fpu_err = 1'b0;
    @(negedge clk) fpu_err = 1'b1;
    @(negedge clk) fpu_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 holds", irq13, 1);
    io_write(16'h92, 8'h00);
    chk("R10 other port", irq13, 1);
    io_write(16'hF1, 8'h00);
    chk("R10 clear F1", irq13, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule